// File: doc/BRIEF.md
# Multifunction Integer ALU

A purely combinational arithmetic and logic unit for a small load/store processor datapath. Two operands enter, one result leaves, and a 3-bit function code picks which of several parallel computations reaches the output: a shared adder/subtractor, three bitwise operations, a bidirectional barrel shifter, an operand pass-through, and a signed compare that returns 0 or 1.

Separate control bits refine each function. One bit picks add or subtract, one picks the shift direction, and one asks for sign fill on right shifts. Two compare enables say whether the compare reports equality, signed less-than, or both. With both enables set, one subtraction yields less-or-equal. The datapath width is a parameter; the shift amount comes from the low log2(width) bits of operand B.

Top module: `mf_alu`

## Requirements
- R1: With func_i = 000, y_o is a_i + b_i when add_i = 1 and a_i - b_i when add_i = 0, both modulo 2^WIDTH.
- R2: func_i = 001 gives a_i AND b_i, 010 gives a_i OR b_i, and 011 gives a_i XOR b_i, bit by bit.
- R3: With func_i = 101, y_o equals a_i.
- R4: With func_i = 100, a_i is shifted left when left_i = 1 and right when left_i = 0. The amount is the low $clog2(WIDTH) bits of b_i, and vacated positions take zeros unless R5 applies. For WIDTH = 32, b_i = 32 shifts by 0.
- R5: A right shift with arith_i = 1 fills vacated positions with a_i's most significant bit. On a left shift, arith_i has no effect and the fill stays zero.
- R6: With func_i = 110 and add_i = 0, y_o[0] = (eq_en_i AND a_i == b_i) OR (lt_en_i AND signed a_i < signed b_i), and all other bits of y_o are zero. With both enables clear, y_o is zero.
- R7: Signed less-than is correct when a_i - b_i overflows. For WIDTH = 32, a_i = 0x80000000 and b_i = 1 gives less-than true, and a_i = 0x7FFFFFFF and b_i = 0xFFFFFFFF gives false.
- R8: With func_i = 111, y_o is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | Operand A; the shifted value and the pass-through value |
| b_i | input | WIDTH | Operand B; its low bits give the shift amount |
| add_i | input | 1 | 1 = add, 0 = subtract (must be 0 for compares) |
| left_i | input | 1 | 1 = shift left, 0 = shift right |
| arith_i | input | 1 | 1 = sign fill on right shifts |
| eq_en_i | input | 1 | Compare reports equality |
| lt_en_i | input | 1 | Compare reports signed less-than |
| func_i | input | 3 | Function select |
| y_o | output | WIDTH | Result |

## Verification
The main instance is built with WIDTH = 6, so all 4096 operand pairs are swept under every function and control setting. This covers every sign combination, every overflowing subtraction and every shift amount. Because WIDTH = 6 is not a power of two, the 3-bit shift amount can also reach 6 and 7, which checks that shifts past the width flush the value completely. A second instance at the default WIDTH = 32 runs directed corners: the most negative operand, compares that overflow, wraparound on add, 31-bit shifts, and shift amounts whose upper bits must be ignored.

// File: rtl/mf_alu_pkg.sv
package mf_alu_pkg;
  typedef enum logic [2:0] {
    FN_ARITH = 3'b000,
    FN_AND   = 3'b001,
    FN_OR    = 3'b010,
    FN_XOR   = 3'b011,
    FN_SHIFT = 3'b100,
    FN_PASS  = 3'b101,
    FN_CMP   = 3'b110,
    FN_NONE  = 3'b111
  } alu_fn_e;
endpackage

// File: rtl/mf_alu_addsub.sv
module mf_alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             add_i,
  output logic [WIDTH-1:0] sum_o
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] cin;

  // subtract as A + ~B + 1; carry-out discarded
  assign b_eff = add_i ? b_i : ~b_i;
  assign cin   = {{(WIDTH-1){1'b0}}, ~add_i};
  assign sum_o = a_i + b_eff + cin;
endmodule

// File: rtl/mf_alu_bitwise.sv
module mf_alu_bitwise
  import mf_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_fn_e          fn_i,
  output logic [WIDTH-1:0] y_o
);
  // one 4-entry truth table, indexed by {a,b}, serves every bit slice
  logic [3:0] lut;

  always_comb begin
    unique case (fn_i)
      FN_AND:  lut = 4'b1000;
      FN_OR:   lut = 4'b1110;
      FN_XOR:  lut = 4'b0110;
      FN_PASS: lut = 4'b1100;
      default: lut = 4'b0000;
    endcase
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    assign y_o[i] = lut[{a_i[i], b_i[i]}];
  end
endmodule

// File: rtl/mf_alu_shifter.sv
module mf_alu_shifter #(
  parameter int WIDTH = 32,
  localparam int ShW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [ShW-1:0]   amt_i,
  input  logic             left_i,
  input  logic             arith_i,
  output logic [WIDTH-1:0] y_o
);
  logic             fill;
  logic [WIDTH-1:0] stage [ShW+1];

  // a single right-shift chain; left shifts mirror the word on entry and exit
  assign fill = arith_i & ~left_i & a_i[WIDTH-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_in
    assign stage[0][i] = left_i ? a_i[WIDTH-1-i] : a_i[i];
  end

  for (genvar k = 0; k < ShW; k++) begin : g_stage
    localparam int Dist = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{Dist{fill}}, stage[k][WIDTH-1:Dist]}
                                 : stage[k];
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_out
    assign y_o[i] = left_i ? stage[ShW][WIDTH-1-i] : stage[ShW][i];
  end
endmodule

// File: rtl/mf_alu_compare.sv
module mf_alu_compare #(
  parameter int WIDTH = 32
) (
  input  logic             a_msb_i,
  input  logic             b_msb_i,
  input  logic [WIDTH-1:0] diff_i,
  input  logic             eq_en_i,
  input  logic             lt_en_i,
  output logic             hit_o
);
  logic is_eq;
  logic is_lt;

  assign is_eq = ~|diff_i;
  // differing signs decide directly; equal signs cannot overflow
  assign is_lt = (a_msb_i & ~b_msb_i) | (~(a_msb_i ^ b_msb_i) & diff_i[WIDTH-1]);
  assign hit_o = (eq_en_i & is_eq) | (lt_en_i & is_lt);
endmodule

// File: rtl/mf_alu.sv
module mf_alu
  import mf_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             add_i,
  input  logic             left_i,
  input  logic             arith_i,
  input  logic             eq_en_i,
  input  logic             lt_en_i,
  input  logic [2:0]       func_i,
  output logic [WIDTH-1:0] y_o
);
  localparam int ShW = $clog2(WIDTH);

  alu_fn_e          fn;
  logic [WIDTH-1:0] sum;
  logic [WIDTH-1:0] bit_res;
  logic [WIDTH-1:0] shf_res;
  logic             cmp_hit;

  assign fn = alu_fn_e'(func_i);

  mf_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i   (a_i),
    .b_i   (b_i),
    .add_i (add_i),
    .sum_o (sum)
  );

  mf_alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
    .a_i  (a_i),
    .b_i  (b_i),
    .fn_i (fn),
    .y_o  (bit_res)
  );

  mf_alu_shifter #(.WIDTH(WIDTH)) u_shifter (
    .a_i     (a_i),
    .amt_i   (b_i[ShW-1:0]),
    .left_i  (left_i),
    .arith_i (arith_i),
    .y_o     (shf_res)
  );

  mf_alu_compare #(.WIDTH(WIDTH)) u_compare (
    .a_msb_i (a_i[WIDTH-1]),
    .b_msb_i (b_i[WIDTH-1]),
    .diff_i  (sum),
    .eq_en_i (eq_en_i),
    .lt_en_i (lt_en_i),
    .hit_o   (cmp_hit)
  );

  always_comb begin
    unique case (fn)
      FN_ARITH:                        y_o = sum;
      FN_AND, FN_OR, FN_XOR, FN_PASS:  y_o = bit_res;
      FN_SHIFT:                        y_o = shf_res;
      FN_CMP:                          y_o = {{(WIDTH-1){1'b0}}, cmp_hit};
      default:                         y_o = '0;
    endcase
  end
endmodule

// File: rtl/mf_alu_chk.sv
module mf_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             add_i,
  input logic             left_i,
  input logic             arith_i,
  input logic             eq_en_i,
  input logic             lt_en_i,
  input logic [2:0]       func_i,
  input logic [WIDTH-1:0] y_o
);
  always_comb begin
    if (func_i == 3'b111)
      p_none_zero_r8: assert (y_o == '0);
    if (func_i == 3'b101)
      p_pass_a_r3: assert (y_o == a_i);
    if (func_i == 3'b110)
      p_cmp_upper_zero_r6: assert (y_o[WIDTH-1:1] == '0);
    if (func_i == 3'b110 && !add_i && !eq_en_i && !lt_en_i)
      p_cmp_disabled_r6: assert (y_o == '0);
    if (func_i == 3'b110 && !add_i && eq_en_i && a_i == b_i)
      p_cmp_equal_r6: assert (y_o[0]);
    if (func_i == 3'b110 && !add_i && lt_en_i && a_i[WIDTH-1] && !b_i[WIDTH-1])
      p_cmp_sign_lt_r7: assert (y_o[0]);
    if (func_i == 3'b100 && left_i && b_i[0])
      p_left_zero_fill_r5: assert (!y_o[0]);
    if (func_i == 3'b001)
      p_and_subset_r2: assert ((y_o & ~(a_i & b_i)) == '0);
    if (func_i == 3'b000 && add_i && b_i == '0)
      p_add_zero_r1: assert (y_o == a_i);
    if (func_i == 3'b100 && !left_i && arith_i && a_i[WIDTH-1] && b_i[0])
      p_sra_sign_r5: assert (y_o[WIDTH-1]);
  end
endmodule

bind mf_alu mf_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .add_i   (add_i),
  .left_i  (left_i),
  .arith_i (arith_i),
  .eq_en_i (eq_en_i),
  .lt_en_i (lt_en_i),
  .func_i  (func_i),
  .y_o     (y_o)
);

// File: tb/mf_alu_tb_top.sv
`timescale 1ns/1ps
module mf_alu_tb_top;
  localparam int SW = 6;
  localparam int LW = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [SW-1:0] s_a, s_b, s_y;
  logic [LW-1:0] l_a, l_b, l_y;
  logic [2:0]    s_fn, l_fn;
  logic s_add, s_left, s_ar, s_eq, s_lt;
  logic l_add, l_left, l_ar, l_eq, l_lt;

  mf_alu #(.WIDTH(SW)) dut_i (
    .a_i(s_a), .b_i(s_b), .add_i(s_add), .left_i(s_left), .arith_i(s_ar),
    .eq_en_i(s_eq), .lt_en_i(s_lt), .func_i(s_fn), .y_o(s_y)
  );

  mf_alu #(.WIDTH(LW)) dut32_i (
    .a_i(l_a), .b_i(l_b), .add_i(l_add), .left_i(l_left), .arith_i(l_ar),
    .eq_en_i(l_eq), .lt_en_i(l_lt), .func_i(l_fn), .y_o(l_y)
  );

  function automatic logic [31:0] model(int w, logic [31:0] a, logic [31:0] b,
                                        logic add, logic left, logic ar,
                                        logic eq, logic lt, logic [2:0] fn);
    logic [63:0] m, a64, b64, as, bs, r;
    int sh;
    m   = (64'd1 << w) - 64'd1;
    a64 = {32'd0, a} & m;
    b64 = {32'd0, b} & m;
    as  = a64[w-1] ? (a64 | ~m) : a64;
    bs  = b64[w-1] ? (b64 | ~m) : b64;
    sh  = int'(b64 & ((64'd1 << $clog2(w)) - 64'd1));
    case (fn)
      3'b000: r = add ? a64 + b64 : a64 - b64;
      3'b001: r = a64 & b64;
      3'b010: r = a64 | b64;
      3'b011: r = a64 ^ b64;
      3'b100: r = left ? (a64 << sh)
                       : (((ar && a64[w-1]) ? (a64 | ~m) : a64) >> sh);
      3'b101: r = a64;
      3'b110: r = {63'd0, (eq && a64 == b64) || (lt && $signed(as) < $signed(bs))};
      default: r = 64'd0;
    endcase
    return 32'(r & m);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // setting index -> controls and requirement tag, for the small sweep
  task automatic small_set(int s, output string req);
    s_add = 1'b0; s_left = 1'b0; s_ar = 1'b0; s_eq = 1'b0; s_lt = 1'b0;
    case (s)
      0:  begin s_fn = 3'b000; s_add = 1'b1; req = "R1 add"; end
      1:  begin s_fn = 3'b000; req = "R1 sub"; end
      2:  begin s_fn = 3'b001; req = "R2 and"; end
      3:  begin s_fn = 3'b010; req = "R2 or"; end
      4:  begin s_fn = 3'b011; req = "R2 xor"; end
      5:  begin s_fn = 3'b101; s_add = 1'b1; req = "R3 pass"; end
      6:  begin s_fn = 3'b100; s_left = 1'b1; req = "R4 shl"; end
      7:  begin s_fn = 3'b100; req = "R4 shr"; end
      8:  begin s_fn = 3'b100; s_ar = 1'b1; req = "R5 sra"; end
      9:  begin s_fn = 3'b100; s_left = 1'b1; s_ar = 1'b1; req = "R5 shl ignores arith"; end
      10: begin s_fn = 3'b110; s_eq = 1'b1; req = "R6 cmp eq"; end
      11: begin s_fn = 3'b110; s_lt = 1'b1; req = "R7 cmp lt"; end
      12: begin s_fn = 3'b110; s_eq = 1'b1; s_lt = 1'b1; req = "R6 cmp le"; end
      13: begin s_fn = 3'b110; req = "R6 cmp disabled"; end
      default: begin s_fn = 3'b111; s_add = 1'b1; s_eq = 1'b1; s_lt = 1'b1;
                     req = "R8 none"; end
    endcase
  endtask

  task automatic big(string req, logic [31:0] a, logic [31:0] b, logic add,
                     logic left, logic ar, logic eq, logic lt, logic [2:0] fn);
    @(negedge clk);
    l_a = a; l_b = b; l_add = add; l_left = left; l_ar = ar;
    l_eq = eq; l_lt = lt; l_fn = fn;
    @(posedge clk); #1;
    check(req, l_y, model(LW, a, b, add, left, ar, eq, lt, fn));
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    string req;
    s_a = '0; s_b = '0; s_fn = 3'b111; s_add = 1'b1;
    s_left = 1'b0; s_ar = 1'b0; s_eq = 1'b0; s_lt = 1'b0;
    l_a = '1; l_b = '1; l_fn = 3'b111; l_add = 1'b1;
    l_left = 1'b0; l_ar = 1'b0; l_eq = 1'b1; l_lt = 1'b1;
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    #1;
    check("R8 initial none", l_y, 32'd0);

    for (int s = 0; s < 15; s++) begin
      for (int a = 0; a < (1 << SW); a++) begin
        for (int b = 0; b < (1 << SW); b++) begin
          @(negedge clk);
          small_set(s, req);
          s_a = SW'(a); s_b = SW'(b);
          @(posedge clk); #1;
          check(req, {26'd0, s_y},
                model(SW, 32'(a), 32'(b), s_add, s_left, s_ar, s_eq, s_lt, s_fn));
        end
      end
    end

    big("R1 add wrap",        32'hFFFF_FFFF, 32'd1,         1, 0, 0, 0, 0, 3'b000);
    big("R1 sub wrap",        32'd0,         32'd1,         0, 0, 0, 0, 0, 3'b000);
    big("R2 xor",             32'hA5A5_0F0F, 32'h0FF0_FF00, 0, 0, 0, 0, 0, 3'b011);
    big("R3 pass",            32'hDEAD_BEEF, 32'h1234_5678, 0, 0, 0, 0, 0, 3'b101);
    big("R4 shl 31",          32'h0000_0003, 32'd31,        0, 1, 0, 0, 0, 3'b100);
    big("R4 shr upper b bits",32'hF000_000A, 32'h0000_0020, 0, 0, 0, 0, 0, 3'b100);
    big("R4 shr 4",           32'h8000_00A0, 32'h7FFF_FFE4, 0, 0, 0, 0, 0, 3'b100);
    big("R5 sra 31",          32'h8000_0000, 32'd31,        0, 0, 1, 0, 0, 3'b100);
    big("R5 sra positive",    32'h4000_0000, 32'd3,         0, 0, 1, 0, 0, 3'b100);
    big("R5 shl arith off",   32'h8000_0001, 32'd1,         0, 1, 1, 0, 0, 3'b100);
    big("R7 min lt 1",        32'h8000_0000, 32'd1,         0, 0, 0, 0, 1, 3'b110);
    big("R7 max lt -1",       32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, 3'b110);
    big("R7 1 lt min",        32'd1,         32'h8000_0000, 0, 0, 0, 1, 1, 3'b110);
    big("R6 le equal",        32'hCAFE_0000, 32'hCAFE_0000, 0, 0, 0, 1, 1, 3'b110);
    big("R6 eq only unequal", 32'd5,         32'd7,         0, 0, 0, 1, 0, 3'b110);
    big("R6 lt neg",          32'hFFFF_FFFE, 32'hFFFF_FFFF, 0, 0, 0, 0, 1, 3'b110);
    big("R8 none",            32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 1, 1, 1, 1, 3'b111);
    check("R7 min lt 1 value", 32'(model(LW, 32'h8000_0000, 32'd1, 0, 0, 0, 0, 1, 3'b110)), 32'd1);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule